// File: doc/BRIEF.md
# Sync-Point Redundant State Comparator

This block watches two or three processors that execute the same work without running in clock-level lockstep. Each processor delivers a state signature only at agreed sync points, and the block compares those signatures once every participating processor has delivered one. Sync points come from three sources: an interrupt taken by a processor, a programmable count of taken branches, and explicit markers that software places in long loops. The block requests a sync point from a lane on an interrupt or on its Nth taken branch. The processor answers with an arrival strobe and its signature, and an explicit marker is simply an arrival strobe sent without a request.

With two lanes, a disagreement raises a fault. With three lanes, a majority vote names the lane that disagrees and locks it out for good. The two lanes that remain are then compared as a pair. If all three signatures differ, there is no majority and a sticky unrecoverable flag is raised. A round that starts but is not completed within a programmable number of cycles is discarded, and the lanes that failed to arrive are reported.

Top module: `sc_syncpt_cmp`

## Requirements
- R1: After reset, `lock_o`, `fatal_o`, `sync_req_o`, `tmo_o`, `cmp_done_o` and `fault_o` are all zero.
- R2: A comparison happens only after every participating lane has strobed in the current round. `cmp_done_o` pulses for one cycle, registered on the clock edge that follows the edge on which the last arrival was sampled.
- R3: When `triple_i`=0, lanes 0 and 1 participate. A signature mismatch pulses `fault_o` together with `cmp_done_o`, and `lock_o` is left unchanged.
- R4: When `triple_i`=1 with three lanes participating, and exactly two signatures agree, the disagreeing lane's bit (bit i is lane i) is set in `lock_o`. `fault_o` pulses. Lockout bits are sticky until reset, and at most one is ever set.
- R5: When `triple_i`=1 with three lanes participating, and all three signatures differ, `fatal_o` is set and stays set until reset. `fault_o` pulses and `lock_o` is not changed.
- R6: A locked-out lane no longer participates. Its strobes are ignored, and the two remaining lanes are compared as a pair, with a mismatch pulsing `fault_o`.
- R7: Each lane counts its own taken branches. On the edge that samples the Nth one (N = `br_limit_i`), `sync_req_o` for that lane rises. With N=0, branches never raise a request.
- R8: `irq_i` for a lane sets that lane's `sync_req_o` on the next edge. An arrival strobe from a participating lane clears that lane's request and its branch count, and the arrival takes priority over an interrupt or branch in the same cycle.
- R9: If a round has started and is still incomplete T+1 cycles after its first arrival edge (T = `timeout_i`), `tmo_o` pulses with a bit set for each participating lane that had not arrived. The round is then discarded without a comparison.
- R10: A second strobe from a lane that has already arrived in the current round is ignored, and the first signature is the one compared.
- R11: When `triple_i`=0, strobes on lane 2 have no effect on comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| triple_i | input | 1 | 1: three-lane voting, 0: two-lane compare on lanes 0 and 1 |
| br_limit_i | input | BR_W | Taken branches per automatic sync point, 0 disables |
| timeout_i | input | TMO_W | Cycles allowed to complete a round |
| br_taken_i | input | 3 | Per-lane taken-branch pulse |
| irq_i | input | 3 | Per-lane interrupt-taken pulse |
| arr_i | input | 3 | Per-lane arrival strobe |
| sig0_i | input | SIG_W | Lane 0 signature |
| sig1_i | input | SIG_W | Lane 1 signature |
| sig2_i | input | SIG_W | Lane 2 signature |
| sync_req_o | output | 3 | Per-lane request to reach a sync point |
| cmp_done_o | output | 1 | Comparison performed (pulse) |
| fault_o | output | 1 | Signatures disagreed (pulse) |
| lock_o | output | 3 | Sticky per-lane lockout |
| fatal_o | output | 1 | Sticky no-majority flag |
| tmo_o | output | 3 | Lanes missing at timeout (pulse) |

## Verification
A comparison result is registered one edge after the edge that samples the final arrival strobe, so the bench expects it two falling edges after it drives that strobe. A timeout is reported T+1 edges after the edge that sampled the first arrival. Each expected result carries its due cycle into a queue. A monitor sampling on the falling edge pops an item whenever `cmp_done_o` or `tmo_o` is active, and compares both the values and the cycle, so an early, late or unrequested result fails. Sync requests are sampled on the falling edge that follows the edge counting the Nth branch or the interrupt.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int LANES = 3;

  typedef enum logic [1:0] {
    V_AGREE = 2'd0,
    V_DIFF  = 2'd1,
    V_ODD   = 2'd2,
    V_NOMAJ = 2'd3
  } verdict_e;
endpackage

// File: rtl/sc_lane_track.sv
module sc_lane_track #(
  parameter int BR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BR_W-1:0] limit_i,
  input  logic            br_i,
  input  logic            irq_i,
  input  logic            acc_i,
  output logic            req_o
);
  logic [BR_W-1:0] cnt_q, cnt_n;
  logic            req_q, req_n;

  always_comb begin
    cnt_n = cnt_q;
    req_n = req_q;
    if (acc_i) begin
      cnt_n = '0;
      req_n = 1'b0;
    end else begin
      if (irq_i) req_n = 1'b1;
      if (br_i && (limit_i != '0)) begin
        if (cnt_q + 1'b1 == limit_i) begin
          cnt_n = '0;
          req_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      req_q <= req_n;
    end
  end

  assign req_o = req_q;

  // R8
  arr_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |=> !req_o);

  // R7
  req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !$past(req_o)) |-> ($past(irq_i) || $past(br_i)));
endmodule

// File: rtl/sc_collect.sv
module sc_collect
  import sc_pkg::*;
#(
  parameter int SIG_W = 16,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] active_i,
  input  logic [LANES-1:0] arr_i,
  input  logic [SIG_W-1:0] sig_i [LANES],
  input  logic [TMO_W-1:0] timeout_i,
  output logic             all_in_o,
  output logic [SIG_W-1:0] sig_o [LANES],
  output logic [LANES-1:0] tmo_o
);
  logic [LANES-1:0] arrived_q, arrived_n;
  logic [LANES-1:0] take;
  logic [TMO_W-1:0] timer_q, timer_n;
  logic [LANES-1:0] tmo_q, tmo_n;
  logic             started, fire;

  assign started  = |arrived_q;
  assign all_in_o = started && ((active_i & ~arrived_q) == '0);
  assign fire     = started && !all_in_o && (timer_q == timeout_i);

  always_comb begin
    tmo_n = '0;
    if (all_in_o) begin
      take = arr_i & active_i;
    end else if (fire) begin
      take  = '0;
      tmo_n = active_i & ~arrived_q;
    end else begin
      take = arr_i & active_i & ~arrived_q;
    end
    if (all_in_o || fire) arrived_n = take;
    else                  arrived_n = arrived_q | take;
    if (!started || all_in_o || fire) timer_n = '0;
    else                              timer_n = timer_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arrived_q <= '0;
      timer_q   <= '0;
      tmo_q     <= '0;
    end else begin
      arrived_q <= arrived_n;
      timer_q   <= timer_n;
      tmo_q     <= tmo_n;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_sig
    logic [SIG_W-1:0] sig_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sig_q <= '0;
      else if (take[g]) sig_q <= sig_i[g];
    end
    assign sig_o[g] = sig_q;
  end

  assign tmo_o = tmo_q;

  // R9
  tmo_discards_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmo_q) |-> (arrived_q == '0));

  // R9
  tmo_only_missing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmo_q) |-> (($past(arrived_q) & tmo_q) == '0));
endmodule

// File: rtl/sc_vote.sv
module sc_vote
  import sc_pkg::*;
#(
  parameter int SIG_W = 16
) (
  input  logic [LANES-1:0] active_i,
  input  logic [SIG_W-1:0] sig_i [LANES],
  output verdict_e         verdict_o,
  output logic [LANES-1:0] odd_o
);
  logic eq01, eq02, eq12, pair_eq;

  assign eq01 = (sig_i[0] == sig_i[1]);
  assign eq02 = (sig_i[0] == sig_i[2]);
  assign eq12 = (sig_i[1] == sig_i[2]);

  always_comb begin
    case (active_i)
      3'b011:  pair_eq = eq01;
      3'b101:  pair_eq = eq02;
      3'b110:  pair_eq = eq12;
      default: pair_eq = 1'b1;
    endcase
  end

  always_comb begin
    verdict_o = V_AGREE;
    odd_o     = '0;
    if (active_i == 3'b111) begin
      if (eq01 && eq02) begin
        verdict_o = V_AGREE;
      end else if (eq01) begin
        verdict_o = V_ODD;
        odd_o     = 3'b100;
      end else if (eq02) begin
        verdict_o = V_ODD;
        odd_o     = 3'b010;
      end else if (eq12) begin
        verdict_o = V_ODD;
        odd_o     = 3'b001;
      end else begin
        verdict_o = V_NOMAJ;
      end
    end else if (!pair_eq) begin
      verdict_o = V_DIFF;
    end
  end
endmodule

// File: rtl/sc_syncpt_cmp.sv
module sc_syncpt_cmp
  import sc_pkg::*;
#(
  parameter int SIG_W = 16,
  parameter int BR_W  = 8,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             triple_i,
  input  logic [BR_W-1:0]  br_limit_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic [2:0]       br_taken_i,
  input  logic [2:0]       irq_i,
  input  logic [2:0]       arr_i,
  input  logic [SIG_W-1:0] sig0_i,
  input  logic [SIG_W-1:0] sig1_i,
  input  logic [SIG_W-1:0] sig2_i,
  output logic [2:0]       sync_req_o,
  output logic             cmp_done_o,
  output logic             fault_o,
  output logic [2:0]       lock_o,
  output logic             fatal_o
  ,output logic [2:0]      tmo_o
);
  logic [SIG_W-1:0] sig_in [LANES];
  logic [SIG_W-1:0] sig_held [LANES];
  logic [LANES-1:0] active, odd, acc;
  logic [LANES-1:0] lock_q, lock_n;
  logic             done_q, done_n, fault_q, fault_n, fatal_q, fatal_n;
  logic             all_in;
  verdict_e         verdict;

  assign sig_in[0] = sig0_i;
  assign sig_in[1] = sig1_i;
  assign sig_in[2] = sig2_i;

  assign active = triple_i ? ~lock_q : 3'b011;
  assign acc    = arr_i & active;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sc_lane_track #(.BR_W(BR_W)) i_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .limit_i (br_limit_i),
      .br_i    (br_taken_i[g]),
      .irq_i   (irq_i[g]),
      .acc_i   (acc[g]),
      .req_o   (sync_req_o[g])
    );
  end

  sc_collect #(.SIG_W(SIG_W), .TMO_W(TMO_W)) i_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (active),
    .arr_i     (arr_i),
    .sig_i     (sig_in),
    .timeout_i (timeout_i),
    .all_in_o  (all_in),
    .sig_o     (sig_held),
    .tmo_o     (tmo_o)
  );

  sc_vote #(.SIG_W(SIG_W)) i_vote (
    .active_i  (active),
    .sig_i     (sig_held),
    .verdict_o (verdict),
    .odd_o     (odd)
  );

  always_comb begin
    done_n  = all_in;
    fault_n = all_in && (verdict != V_AGREE);
    lock_n  = lock_q;
    fatal_n = fatal_q;
    if (all_in && (verdict == V_ODD))   lock_n  = lock_q | odd;
    if (all_in && (verdict == V_NOMAJ)) fatal_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      lock_q  <= '0;
      fatal_q <= 1'b0;
    end else begin
      done_q  <= done_n;
      fault_q <= fault_n;
      lock_q  <= lock_n;
      fatal_q <= fatal_n;
    end
  end

  assign cmp_done_o = done_q;
  assign fault_o    = fault_q;
  assign lock_o     = lock_q;
  assign fatal_o    = fatal_q;

  // R2
  done_after_full_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done_o |-> $past(all_in));

  // R2
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> cmp_done_o);

  // R4
  single_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_o));

  // R4
  lockout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o & $past(lock_o)) == $past(lock_o));

  // R3
  dual_never_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o != $past(lock_o)) |-> $past(triple_i));

  // R5
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |=> fatal_o);
endmodule

// File: tb/test_sc_syncpt_cmp.sv
module test_sc_syncpt_cmp;
  localparam int SIG_W = 16;
  localparam int BR_W  = 8;
  localparam int TMO_W = 8;

  typedef struct {
    logic       done;
    logic       fault;
    logic [2:0] lock;
    logic       fatal;
    logic [2:0] tmo;
    int         due;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic triple;
  logic [BR_W-1:0]  br_limit;
  logic [TMO_W-1:0] timeout;
  logic [2:0] br_taken, irq, arr;
  logic [SIG_W-1:0] s0, s1, s2;
  logic [2:0] sync_req, lock, tmo;
  logic done, fault, fatal;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sc_syncpt_cmp #(.SIG_W(SIG_W), .BR_W(BR_W), .TMO_W(TMO_W)) i_sc_syncpt_cmp (
    .clk(clk), .rst_n(rst_n), .triple_i(triple), .br_limit_i(br_limit),
    .timeout_i(timeout), .br_taken_i(br_taken), .irq_i(irq), .arr_i(arr),
    .sig0_i(s0), .sig1_i(s1), .sig2_i(s2), .sync_req_o(sync_req),
    .cmp_done_o(done), .fault_o(fault), .lock_o(lock), .fatal_o(fatal),
    .tmo_o(tmo)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops an expected item whenever the design reports a result
  always @(negedge clk) begin
    if (rst_n && (done || (tmo != 3'b000))) begin
      if (sb.size() == 0) begin
        check(0, "R2 unexpected result", $sformatf("done=%b tmo=%b cyc=%0d", done, tmo, cyc), "none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(done == e.done && fault == e.fault && lock == e.lock && fatal == e.fatal &&
              tmo == e.tmo && cyc == e.due, e.tag,
              $sformatf("done=%b fault=%b lock=%b fatal=%b tmo=%b cyc=%0d", done, fault, lock, fatal, tmo, cyc),
              $sformatf("done=%b fault=%b lock=%b fatal=%b tmo=%b cyc=%0d", e.done, e.fault, e.lock, e.fatal, e.tmo, e.due));
      end
    end
  end

  task automatic push(input logic d, input logic f, input logic [2:0] l, input logic ft,
                      input logic [2:0] t, input int due, input string tag);
    exp_t e;
    e.done = d; e.fault = f; e.lock = l; e.fatal = ft; e.tmo = t; e.due = due; e.tag = tag;
    sb.push_back(e);
  endtask

  // drives one strobe cycle; returns the cycle count seen when driving
  task automatic strobe(input logic [2:0] m, input logic [SIG_W-1:0] a,
                        input logic [SIG_W-1:0] b, input logic [SIG_W-1:0] c, output int dc);
    @(negedge clk);
    dc = cyc;
    arr = m; s0 = a; s1 = b; s2 = c;
    @(negedge clk);
    arr = 3'b000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int dc;
    rst_n = 1'b0; triple = 1'b0; br_limit = 8'd3; timeout = 8'd20;
    br_taken = '0; irq = '0; arr = '0; s0 = '0; s1 = '0; s2 = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(lock == 0 && !fatal && sync_req == 0 && tmo == 0 && !done && !fault, "R1 reset",
          $sformatf("lock=%b fatal=%b req=%b", lock, fatal, sync_req), "all zero");

    // R11 / R3 dual agreement with noise on lane 2
    strobe(3'b111, 16'h1234, 16'h1234, 16'hdead, dc);
    push(1, 0, 3'b000, 0, 3'b000, dc + 2, "R11 dual agree, lane2 ignored");
    idle(3);

    // R2 / R10 split arrival, second strobe of lane 0 ignored
    strobe(3'b001, 16'h0055, 16'h0, 16'h0, dc);
    strobe(3'b001, 16'h0099, 16'h0, 16'h0, dc);
    idle(2);
    strobe(3'b010, 16'h0, 16'h0055, 16'h0, dc);
    push(1, 0, 3'b000, 0, 3'b000, dc + 2, "R10 first signature kept / R2 timing");
    idle(3);

    // R3 dual mismatch
    strobe(3'b011, 16'h0001, 16'h0002, 16'h0, dc);
    push(1, 1, 3'b000, 0, 3'b000, dc + 2, "R3 dual mismatch");
    idle(3);

    // R7 branch-driven request, N=3
    @(negedge clk); br_taken = 3'b001;
    @(negedge clk);
    @(negedge clk); br_taken = 3'b000;
    check(sync_req == 3'b000, "R7 two branches", $sformatf("%b", sync_req), "000");
    @(negedge clk); br_taken = 3'b001;
    @(negedge clk); br_taken = 3'b000;
    check(sync_req == 3'b001, "R7 third branch", $sformatf("%b", sync_req), "001");

    // R8 interrupt request, then arrival clears
    @(negedge clk); irq = 3'b010;
    @(negedge clk); irq = 3'b000;
    check(sync_req == 3'b011, "R8 irq request", $sformatf("%b", sync_req), "011");
    strobe(3'b011, 16'h7777, 16'h7777, 16'h0, dc);
    push(1, 0, 3'b000, 0, 3'b000, dc + 2, "R8 sync round");
    check(sync_req == 3'b000, "R8 arrival clears", $sformatf("%b", sync_req), "000");
    idle(2);

    // R7 N=0 disables
    br_limit = 8'd0;
    @(negedge clk); br_taken = 3'b010;
    idle(6);
    br_taken = 3'b000;
    @(negedge clk);
    check(sync_req == 3'b000, "R7 limit zero", $sformatf("%b", sync_req), "000");
    br_limit = 8'd3;

    // triple mode
    triple = 1'b1;
    @(negedge clk);
    strobe(3'b111, 16'h00aa, 16'h00aa, 16'h00aa, dc);
    push(1, 0, 3'b000, 0, 3'b000, dc + 2, "R4 triple agree");
    idle(3);

    // R4 lane 1 disagrees
    strobe(3'b111, 16'h0100, 16'h0bad, 16'h0100, dc);
    push(1, 1, 3'b010, 0, 3'b000, dc + 2, "R4 lane1 locked");
    idle(3);

    // R6 locked lane alone produces nothing, then pair compare
    strobe(3'b010, 16'h0, 16'h1111, 16'h0, dc);
    idle(4);
    strobe(3'b111, 16'h0200, 16'h0333, 16'h0200, dc);
    push(1, 0, 3'b010, 0, 3'b000, dc + 2, "R6 degraded agree");
    idle(3);
    strobe(3'b101, 16'h0300, 16'h0, 16'h0301, dc);
    push(1, 1, 3'b010, 0, 3'b000, dc + 2, "R6 degraded mismatch");
    idle(3);
    check(lock == 3'b010, "R4 lockout sticky", $sformatf("%b", lock), "010");

    // restart with full set
    do_reset();
    check(lock == 0 && !fatal, "R1 reset again", $sformatf("lock=%b fatal=%b", lock, fatal), "0/0");

    // R9 timeout, lane 1 missing
    timeout = 8'd5;
    strobe(3'b101, 16'h0042, 16'h0, 16'h0042, dc);
    push(0, 0, 3'b000, 0, 3'b010, dc + 5 + 2, "R9 timeout lane1");
    idle(10);
    timeout = 8'd20;
    strobe(3'b111, 16'h0050, 16'h0050, 16'h0050, dc);
    push(1, 0, 3'b000, 0, 3'b000, dc + 2, "R9 next round clean");
    idle(3);

    // R5 no majority
    strobe(3'b111, 16'h0001, 16'h0002, 16'h0003, dc);
    push(1, 1, 3'b000, 1, 3'b000, dc + 2, "R5 no majority");
    idle(3);
    strobe(3'b111, 16'h0009, 16'h0009, 16'h0009, dc);
    push(1, 0, 3'b000, 1, 3'b000, dc + 2, "R5 fatal sticky");
    idle(4);

    check(sb.size() == 0, "R2 all results seen", $sformatf("%0d", sb.size()), "0");
    finish_run();
  end
endmodule